// File: doc/BRIEF.md
# Bus-Master Latency Timer with Configuration Byte Slice

This block holds four bytes of a bus device's configuration header and runs the master latency timer that goes with one of them. The bytes are a programming-interface code and a base-class code, both fixed by an operating-mode strap, plus a cache-line-size byte and a latency-limit byte that software can write. A single-cycle byte port writes the registers. Read data is combinational on the address, so reads have no wait states.

While the device masters a transaction, the timer counts clocks in which the bus grant is withdrawn. Clocks with grant present are not counted. The limit is the latency byte as read, so it comes in steps of 8 clocks. Once that limit is used up, `lat_expired` tells the master to finish its transaction. The flag stays up until the transaction ends. The strap is captured only during reset.

Every pin is a plain control or status signal. Configuration access is a one-cycle strobe that cannot be refused, so the port has no valid/ready handshake and no back-pressure.

Top module: `pci_lat_slice`

## Requirements
- R1: After a synchronous active-high reset, the cache-line byte and the latency byte read 0x00 and `lat_expired` is low.
- R2: The latency byte sits at address 0x0D. A write stores bits 7..3 of the write data. Bits 2..0 always read as zero.
- R3: The cache-line byte sits at address 0x0C. A write of 0x08 stores 0x08. A write of any other value leaves it at 0x00.
- R4: The programming-interface byte sits at address 0x09. It reads 0x00 when the captured strap is 0 (host bridge) and 0x01 when it is 1 (agent). Writes to it are ignored.
- R5: The base-class byte sits at address 0x0B. It reads 0x06 in host-bridge mode and 0x0E in agent mode. Writes to it are ignored.
- R6: The mode strap is sampled only on clock edges where reset is high. Strap changes outside reset do not change the read values.
- R7: While `xact_active` is low, the timer count is zero and `lat_expired` is low on the next clock.
- R8: Within a transaction, the count advances on each clock with `xact_active` high and `gnt_active` low, and holds while grant is high. `lat_expired` rises after the edge on which the count reaches max(limit,1). A limit of 0 therefore expires on the first clock without grant.
- R9: Once `lat_expired` is high, it stays high while `xact_active` stays high, even if grant returns.
- R10: Reads of any other address return 0x00. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_agent | input | 1 | Mode strap: 1 = agent, 0 = host bridge |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_we | input | 1 | Write strobe for one cycle |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| xact_active | input | 1 | Device is mastering a transaction |
| gnt_active | input | 1 | Bus grant is asserted to this device |
| lat_expired | output | 1 | Latency limit used up; master must finish |

## Verification
The embedded assertions check on every cycle that the cache-line byte only ever holds 0 or 8, and that the latency byte's low bits read as zero. They also check that the captured mode never moves outside reset, that the expired flag clears when the master goes idle and stays up while it stays busy, and that the flag can only rise on a clock without grant. Only the bench's scenarios can show the exact expiry cycle for a given limit. The same goes for the holding of the count across grant-high gaps, the mode-dependent codes after each reset, and the fact that writes to read-only bytes leave them unchanged.

// File: rtl/pci_lat_pkg.sv
package pci_lat_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] ADDR_PIF = 8'h09;
  localparam logic [7:0] ADDR_CLASS = 8'h0B;
  localparam logic [7:0] ADDR_CLS = 8'h0C;
  localparam logic [7:0] ADDR_LAT = 8'h0D;

  typedef enum logic {MODE_HOST = 1'b0, MODE_AGENT = 1'b1} dev_mode_e;

  typedef struct packed {
    logic [7:0] pif;
    logic [7:0] cls;
  } mode_codes_t;

  function automatic mode_codes_t codes_for(dev_mode_e m);
    mode_codes_t c;
    c.pif = (m == MODE_AGENT) ? 8'h01 : 8'h00;
    c.cls = (m == MODE_AGENT) ? 8'h0E : 8'h06;
    return c;
  endfunction
endpackage

// File: rtl/pci_lat_mode.sv
module pci_lat_mode
  import pci_lat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strap,
  output dev_mode_e mode
);
  dev_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= dev_mode_e'(strap);
  end

  assign mode = mode_q;

  // R6: captured mode moves only on reset edges
  a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
endmodule

// File: rtl/pci_lat_regs.sv
module pci_lat_regs
  import pci_lat_pkg::*;
#(
  parameter int GRAN_BITS = 3,
  parameter logic [7:0] CLS_LEGAL = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  dev_mode_e         mode,
  input  logic [7:0]        addr,
  input  logic              we,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        lat_limit
);
  localparam int HI_W = BYTE_W - GRAN_BITS;

  logic [HI_W-1:0] lat_hi_q;
  logic [7:0]      cls_q;
  mode_codes_t     codes;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_hi_q <= '0;
      cls_q    <= '0;
    end else if (we) begin
      if (addr == ADDR_LAT) lat_hi_q <= wdata[BYTE_W-1:GRAN_BITS];
      if (addr == ADDR_CLS) cls_q <= (wdata == CLS_LEGAL) ? CLS_LEGAL : 8'h00;
    end
  end

  assign lat_limit = {lat_hi_q, {GRAN_BITS{1'b0}}};
  assign codes = codes_for(mode);

  always_comb begin
    unique case (addr)
      ADDR_PIF:   rdata = codes.pif;
      ADDR_CLASS: rdata = codes.cls;
      ADDR_CLS:   rdata = cls_q;
      ADDR_LAT:   rdata = lat_limit;
      default:    rdata = 8'h00;
    endcase
  end

  // R3: cache-line byte only ever holds 0 or the legal size
  a_r3_cls_legal: assert property (@(posedge clk) disable iff (rst)
    (cls_q == 8'h00) || (cls_q == CLS_LEGAL));
  // R3: an illegal write clears it
  a_r3_bad_write_clears: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_CLS && wdata != CLS_LEGAL) |=> (cls_q == 8'h00));
endmodule

// File: rtl/pci_lat_timer.sv
module pci_lat_timer #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       gnt,
  input  logic [7:0] limit,
  output logic       expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_next;
  logic             exp_q;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!gnt) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_next[CNT_W-1:0];
      if (cnt_next >= (CNT_W+1)'(limit)) exp_q <= 1'b1;
    end
  end

  assign expired = exp_q;

  // R7: idle master clears the flag
  a_r7_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !active |=> !expired);
  // R9: flag is sticky while the transaction lasts
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && active) |=> expired);
  // R8: the flag only rises after a clock without grant
  a_r8_rise_needs_no_gnt: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> $past(!gnt && active));
endmodule

// File: rtl/pci_lat_slice.sv
module pci_lat_slice
  import pci_lat_pkg::*;
#(
  parameter int GRAN_BITS = 3,
  parameter int CNT_W = 8,
  parameter logic [7:0] CLS_LEGAL = 8'h08
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_agent,
  input  logic [7:0] cfg_addr,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       xact_active,
  input  logic       gnt_active,
  output logic       lat_expired
);
  dev_mode_e  mode;
  logic [7:0] lat_limit;

  pci_lat_mode u_mode (
    .clk(clk), .rst(rst), .strap(mode_agent), .mode(mode)
  );

  pci_lat_regs #(.GRAN_BITS(GRAN_BITS), .CLS_LEGAL(CLS_LEGAL)) u_regs (
    .clk(clk), .rst(rst), .mode(mode), .addr(cfg_addr), .we(cfg_we),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .lat_limit(lat_limit)
  );

  pci_lat_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .active(xact_active), .gnt(gnt_active),
    .limit(lat_limit), .expired(lat_expired)
  );

  // R2: latency byte low bits read as zero at the port
  a_r2_lat_low_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == ADDR_LAT) |-> (cfg_rdata[GRAN_BITS-1:0] == '0));
endmodule

// File: tb/tb_pci_lat_slice.sv
module tb_pci_lat_slice;
  logic clk = 1'b0;
  logic rst, strap, we, act, gnt;
  logic [7:0] addr, wdata, rdata;
  logic expired;
  int checks = 0, fails = 0;

  int m_cls, m_lat, m_cnt;
  bit m_mode, m_exp;

  always #2 clk = ~clk;

  pci_lat_slice dut (
    .clk(clk), .rst(rst), .mode_agent(strap), .cfg_addr(addr),
    .cfg_we(we), .cfg_wdata(wdata), .cfg_rdata(rdata),
    .xact_active(act), .gnt_active(gnt), .lat_expired(expired)
  );

  function automatic int exp_read(input logic [7:0] a);
    case (a)
      8'h09: return m_mode ? 8'h01 : 8'h00;
      8'h0B: return m_mode ? 8'h0E : 8'h06;
      8'h0C: return m_cls;
      8'h0D: return m_lat;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    case (a)
      8'h09: return "R4";
      8'h0B: return "R5";
      8'h0C: return "R3";
      8'h0D: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // one cycle: entered at a negedge, leaves at the next negedge
  task automatic step(input bit r, input bit s, input bit w, input logic [7:0] a,
                      input logic [7:0] d, input bit ac, input bit g);
    int nc;
    rst = r; strap = s; we = w; addr = a; wdata = d; act = ac; gnt = g;
    #1;
    if (!r) check(tag_for(a), rdata, exp_read(a));
    @(posedge clk);
    if (r) begin
      m_cls = 0; m_lat = 0; m_mode = s; m_cnt = 0; m_exp = 0;
    end else begin
      if (!ac) begin m_cnt = 0; m_exp = 0; end
      else if (!g) begin
        nc = m_cnt + 1;
        if (nc >= m_lat) m_exp = 1;
        m_cnt = (nc > 255) ? 255 : nc;
      end
      if (w && a == 8'h0D) m_lat = d & 8'hF8;
      if (w && a == 8'h0C) m_cls = (d == 8'h08) ? 8'h08 : 0;
    end
    @(negedge clk);
    check("R7 R8 R9 expired", expired, m_exp);
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed = 32'h5A17;
    void'($urandom(seed));
    rst = 1; strap = 0; we = 0; addr = 0; wdata = 0; act = 0; gnt = 1;
    @(negedge clk);
    step(1, 0, 0, 8'h0C, 0, 0, 1);
    // R1 reset values
    addr = 8'h0C; #1; check("R1 cls", rdata, 0);
    addr = 8'h0D; #1; check("R1 lat", rdata, 0);
    check("R1 expired", expired, 0);
    @(negedge clk);
    // R4 R5 host mode, writes ignored
    step(0, 1, 1, 8'h09, 8'hFF, 0, 1);
    step(0, 1, 1, 8'h0B, 8'hFF, 0, 1);
    step(0, 1, 0, 8'h09, 0, 0, 1);
    step(0, 0, 0, 8'h0B, 0, 0, 1);
    // R3 legal then illegal
    step(0, 0, 1, 8'h0C, 8'h08, 0, 1);
    step(0, 0, 1, 8'h0C, 8'h10, 0, 1);
    step(0, 0, 0, 8'h0C, 0, 0, 1);
    // R2 low bits masked
    step(0, 0, 1, 8'h0D, 8'h0F, 0, 1);
    step(0, 0, 0, 8'h0D, 0, 0, 1);
    // R8 limit 8 with a grant-high gap; R9 grant returns after expiry
    step(0, 0, 0, 8'h0D, 0, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 8'h0D, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8'h0D, 0, 1, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 8'h0D, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8'h0D, 0, 1, 1);
    step(0, 0, 0, 8'h0D, 0, 0, 1);
    // R8 limit 0 expires on first no-grant clock
    step(0, 0, 1, 8'h0D, 8'h07, 1, 1);
    step(0, 0, 0, 8'h0D, 0, 1, 0);
    step(0, 0, 0, 8'h0D, 0, 0, 0);
    // R6 agent mode reset, strap then drops
    step(1, 1, 0, 8'h09, 0, 0, 1);
    step(0, 0, 0, 8'h09, 0, 0, 1);
    step(0, 0, 0, 8'h0B, 0, 0, 1);
    step(0, 0, 0, 8'h42, 0, 0, 1); // R10 unmapped
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a, d;
      bit w, ac, g, r, s;
      case ($urandom_range(5))
        0: a = 8'h09; 1: a = 8'h0B; 2: a = 8'h0C; 3: a = 8'h0D;
        4: a = 8'h0C; default: a = 8'($urandom);
      endcase
      d = ($urandom_range(3) == 0) ? 8'h08 : ($urandom_range(1) ? 8'($urandom) & 8'h3F : 8'($urandom));
      w = ($urandom_range(3) == 0);
      ac = ($urandom_range(15) != 0);
      g = ($urandom_range(2) == 0);
      r = ($urandom_range(400) == 0);
      s = 1'($urandom);
      step(r, s, w, a, d, ac, g);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule